// File: doc/BRIEF.md
# Circular Sample Buffer Readout Engine

This block keeps the most recent 10-bit samples in a ring of fixed depth (50 by default) and hands them out one byte at a time to a serial slave that is answering a read burst. Samples arrive on a simple valid/data write port. Each accepted sample overwrites the oldest slot.

When the pointer logic pulses `rd_start`, the engine freezes the ring and begins a readout in a rotated chronological order. The first sample out is the one just after the oldest. The samples then run forward in time to the newest, and the oldest comes out last. The current byte is always on `rd_data`. Each master acknowledge (`rd_ack`) moves to the next byte, and a master NACK (`rd_nack`) ends the readout.

Two byte formats are available, chosen by `rd_wide` at start. The narrow format sends one byte per sample, holding the sample's upper eight bits. The wide format sends two bytes per sample: first the upper eight bits, then a byte with the two low bits right-justified in bits [1:0] and zeros above them.

Top module: `cbuf_readout`

## Requirements
- R1: After reset (rst_n low, active low), rd_active is 0, rd_data is 0, every ring slot holds 0 and the write pointer is at slot 0.
- R2: While no readout is active, each cycle with wr_valid high stores wr_data into the slot at the write pointer. The pointer then advances by one and wraps from DEPTH-1 to 0, so the ring always holds the last DEPTH samples.
- R3: While rd_active is 1, wr_valid is ignored and the ring contents and write pointer do not change.
- R4: A cycle with rd_start high (and rd_nack low) sets rd_active on the next cycle. It presents the first byte of the next-to-oldest sample, and a start during an active readout restarts it from that point.
- R5: Readout order is: next-to-oldest sample, then each more recent sample in turn up to the newest, and finally the oldest sample as the DEPTH-th sample.
- R6: In narrow mode (rd_wide=0 at start) each byte equals bits [9:2] of its sample.
- R7: In wide mode (rd_wide=1 at start) each sample gives two bytes. The first is bits [9:2]; the second is {6'b0, bits [1:0]}.
- R8: Each rd_ack cycle during an active readout advances exactly one byte, visible the next cycle. rd_ack while idle has no effect.
- R9: rd_nack ends the readout: on the next cycle rd_active is 0 and rd_data is 0. rd_nack takes priority over rd_ack and rd_start in the same cycle.
- R10: An acknowledge of the last byte of the DEPTH-th sample wraps the sequence back to the first byte of the next-to-oldest sample.
- R11: The format is fixed at start; changes on rd_wide during a readout have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | 10 | Sample value |
| rd_start | input | 1 | Begin (or restart) a readout |
| rd_wide | input | 1 | Format select at start: 0 narrow, 1 wide |
| rd_ack | input | 1 | Master acknowledged current byte; advance |
| rd_nack | input | 1 | Master NACK; end readout |
| rd_data | output | 8 | Current byte of the readout (0 when idle) |
| rd_active | output | 1 | A readout is in progress |

## Verification
All state changes take effect on the clock edge after the input that causes them. A start, acknowledge or NACK is therefore visible on `rd_data`/`rd_active` one cycle later, and `rd_data` is a combinational read of that registered state. A write is visible to a readout started on any later cycle. The bench drives each input just after a falling edge, lets one rising edge pass, and samples at the following falling edge, so every check sits exactly one cycle after its stimulus. Expected bytes come from the bench's own history of every accepted write, indexed by recency rather than by ring slot.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  localparam int SMP_W = 10;

  typedef enum logic {
    FMT_NARROW = 1'b0,
    FMT_WIDE   = 1'b1
  } rd_fmt_e;

  // Ring slot holding the sample at readout position 'offset'.
  // The oldest sample lives at 'wptr'; position 0 is the one after it.
  function automatic int unsigned ring_slot(int unsigned wptr,
                                            int unsigned offset,
                                            int unsigned depth);
    int unsigned s;
    s = wptr + 1 + offset;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Byte presented for a sample, given format and which half of a wide pair.
  function automatic logic [7:0] fmt_byte(logic [SMP_W-1:0] smp,
                                          rd_fmt_e fmt,
                                          logic second);
    if (fmt == FMT_WIDE && second) return {6'b0, smp[1:0]};
    return smp[SMP_W-1:2];
  endfunction

endpackage

// File: rtl/sample_ring.sv
module sample_ring #(
  parameter int DEPTH = 50,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [cbuf_pkg::SMP_W-1:0] wr_data,
  input  logic [PTR_W-1:0]           rd_slot,
  output logic [cbuf_pkg::SMP_W-1:0] rd_sample,
  output logic [PTR_W-1:0]           wr_ptr
);

  logic [cbuf_pkg::SMP_W-1:0] mem [DEPTH];

  logic ptr_at_end;
  assign ptr_at_end = (wr_ptr == PTR_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ptr] <= wr_data;
      wr_ptr      <= ptr_at_end ? '0 : wr_ptr + 1'b1;
    end
  end

  assign rd_sample = mem[rd_slot];

  AST_WPTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr < PTR_W'(DEPTH)); // R2

  AST_WPTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr_at_end |=> wr_ptr == '0); // R2

  AST_WPTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr)); // R3

endmodule

// File: rtl/read_sequencer.sv
module read_sequencer #(
  parameter int DEPTH = 50,
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_in,
  input  logic              ack,
  input  logic              nack,
  output logic              active,
  output logic [POS_W-1:0]  pos,
  output logic              second,
  output cbuf_pkg::rd_fmt_e fmt_q,
  output logic              seq_step,
  output logic              seq_wrap
);

  import cbuf_pkg::*;

  logic sample_done;
  logic pos_at_end;

  // Named events for the assertions and the top.
  assign seq_step    = active && ack && !nack && !start;
  assign sample_done = (fmt_q == FMT_NARROW) || second;
  assign pos_at_end  = (pos == POS_W'(DEPTH - 1));
  assign seq_wrap    = seq_step && sample_done && pos_at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      second <= 1'b0;
      fmt_q  <= FMT_NARROW;
    end else if (nack) begin
      active <= 1'b0;
      pos    <= '0;
      second <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      pos    <= '0;
      second <= 1'b0;
      fmt_q  <= wide_in ? FMT_WIDE : FMT_NARROW;
    end else if (seq_step) begin
      if (!sample_done) begin
        second <= 1'b1;
      end else begin
        second <= 1'b0;
        pos    <= pos_at_end ? '0 : pos + 1'b1;
      end
    end
  end

  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> !active); // R9

  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start && !nack |=> active && pos == '0 && !second); // R4

  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !active && ack && !start && !nack |=> !active && $stable(pos)); // R8

  AST_NARROW_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q == FMT_NARROW |-> !second); // R6

  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wrap |=> active && pos == '0 && !second); // R10

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(fmt_q)); // R11

  AST_POS_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    pos < POS_W'(DEPTH)); // R5

endmodule

// File: rtl/cbuf_readout.sv
module cbuf_readout #(
  parameter int DEPTH = 50,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [9:0] wr_data,
  input  logic       rd_start,
  input  logic       rd_wide,
  input  logic       rd_ack,
  input  logic       rd_nack,
  output logic [7:0] rd_data,
  output logic       rd_active
);

  import cbuf_pkg::*;

  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_slot;
  logic [SMP_W-1:0] rd_sample;
  logic [PTR_W-1:0] pos;
  logic             second;
  rd_fmt_e          fmt_q;
  logic             seq_step;
  logic             seq_wrap;

  // Ring is frozen for the whole readout.
  assign wr_en = wr_valid && !rd_active;

  sample_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_slot   (rd_slot),
    .rd_sample (rd_sample),
    .wr_ptr    (wr_ptr)
  );

  read_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rd_start),
    .wide_in  (rd_wide),
    .ack      (rd_ack),
    .nack     (rd_nack),
    .active   (rd_active),
    .pos      (pos),
    .second   (second),
    .fmt_q    (fmt_q),
    .seq_step (seq_step),
    .seq_wrap (seq_wrap)
  );

  assign rd_slot = PTR_W'(ring_slot(32'(wr_ptr), 32'(pos), DEPTH));
  assign rd_data = rd_active ? fmt_byte(rd_sample, fmt_q, second) : 8'h00;

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && wr_valid |=> $stable(wr_ptr)); // R3

  AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active && wr_valid |=> wr_ptr != $past(wr_ptr)); // R2

  AST_SLOT_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot < PTR_W'(DEPTH)); // R5

  AST_STEP_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step |-> rd_active && !seq_wrap || pos == PTR_W'(DEPTH - 1)); // R8

endmodule

// File: tb/tb_cbuf_readout.sv
module tb_cbuf_readout;

  localparam int DEPTH = 50;

  // Vector table: {wide[20], write_count[19:10], seed[9:0]}
  localparam int NVEC = 6;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 10'd50,  10'd3},
    {1'b1, 10'd7,   10'd100},
    {1'b0, 10'd120, 10'd511},
    {1'b1, 10'd49,  10'd21},
    {1'b0, 10'd1,   10'd999},
    {1'b1, 10'd200, 10'd77}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [9:0] wr_data = '0;
  logic       rd_start = 1'b0;
  logic       rd_wide = 1'b0;
  logic       rd_ack = 1'b0;
  logic       rd_nack = 1'b0;
  logic [7:0] rd_data;
  logic       rd_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int hist [1024];
  int total = 0;

  always #10 clk = ~clk;

  cbuf_readout #(.DEPTH(DEPTH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_start  (rd_start),
    .rd_wide   (rd_wide),
    .rd_ack    (rd_ack),
    .rd_nack   (rd_nack),
    .rd_data   (rd_data),
    .rd_active (rd_active)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Sample at readout position k, by recency over the write history.
  function automatic int exp_sample(int k);
    int j;
    j = (k == DEPTH - 1) ? total - DEPTH : total - DEPTH + 1 + k;
    return (j >= 0) ? hist[j] : 0;
  endfunction

  function automatic int hi_b(int s);  return (s >> 2) & 8'hFF; endfunction
  function automatic int lo_b(int s);  return s & 3;            endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_write(int v, bit counted);
    wr_valid = 1'b1; wr_data = 10'(v);
    cyc();
    wr_valid = 1'b0;
    if (counted) begin hist[total] = v & 10'h3FF; total++; end
  endtask

  task automatic do_start(bit wide);
    rd_start = 1'b1; rd_wide = wide;
    cyc();
    rd_start = 1'b0;
  endtask

  task automatic do_ack();
    rd_ack = 1'b1; cyc(); rd_ack = 1'b0;
  endtask

  task automatic do_nack();
    rd_nack = 1'b1; cyc(); rd_nack = 1'b0;
    chk("R9 nack ends active", int'(rd_active), 0);
    chk("R9 idle data zero", int'(rd_data), 0);
  endtask

  // Full readout plus one wrap step, checked byte by byte.
  task automatic read_all(bit wide);
    do_start(wide);
    chk("R4 active after start", int'(rd_active), 1);
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = exp_sample(k);
      if (k == 0)              chk("R4 first is next-to-oldest", int'(rd_data), hi_b(s));
      else if (k == DEPTH - 1) chk("R5 oldest comes last", int'(rd_data), hi_b(s));
      else if (wide)           chk("R7 high byte in order R5", int'(rd_data), hi_b(s));
      else                     chk("R6 narrow byte in order R5", int'(rd_data), hi_b(s));
      do_ack();
      if (wide) begin
        chk("R7 low bits byte", int'(rd_data), lo_b(s));
        do_ack();
      end
    end
    chk("R10 wrap to first", int'(rd_data), hi_b(exp_sample(0)));
    do_nack();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) cyc();
    chk("R1 active after reset", int'(rd_active), 0);
    chk("R1 data after reset", int'(rd_data), 0);
    rst_n = 1'b1;
    cyc();
    // R8: idle acks ignored; R1: cleared ring reads zero
    do_ack(); do_ack();
    chk("R8 idle ack keeps idle", int'(rd_active), 0);
    do_start(1'b0);
    chk("R1 cleared slot", int'(rd_data), 0);
    do_nack();

    // Table-driven runs (R2, R5, R6, R7, R10)
    for (int v = 0; v < NVEC; v++) begin
      int nwr, seed;
      nwr  = int'(VEC[v][19:10]);
      seed = int'(VEC[v][9:0]);
      for (int i = 0; i < nwr; i++)
        do_write((seed * 37 + total * 13 + total * total) & 10'h3FF, 1'b1);
      read_all(VEC[v][20]);
    end

    // R3: writes during readout ignored
    do_start(1'b0);
    do_write(10'h3FF, 1'b0);
    do_write(10'h155, 1'b0);
    chk("R3 data unchanged under writes", int'(rd_data), hi_b(exp_sample(0)));
    do_nack();
    read_all(1'b0);

    // R9: nack beats ack in the same cycle
    do_start(1'b1);
    rd_ack = 1'b1; rd_nack = 1'b1; cyc(); rd_ack = 1'b0; rd_nack = 1'b0;
    chk("R9 nack over ack", int'(rd_active), 0);
    chk("R9 data zero after nack", int'(rd_data), 0);
    // R9: nack beats start
    rd_start = 1'b1; rd_nack = 1'b1; cyc(); rd_start = 1'b0; rd_nack = 1'b0;
    chk("R9 nack over start", int'(rd_active), 0);

    // R11: format held while rd_wide toggles
    do_start(1'b1);
    rd_wide = 1'b0;
    do_ack();
    chk("R11 wide kept for low byte", int'(rd_data), lo_b(exp_sample(0)));
    do_ack();
    chk("R11 next sample high byte", int'(rd_data), hi_b(exp_sample(1)));

    // R4: restart while active
    do_ack(); do_ack();
    do_start(1'b0);
    chk("R4 restart from first", int'(rd_data), hi_b(exp_sample(0)));
    do_ack();
    chk("R8 one ack one sample", int'(rd_data), hi_b(exp_sample(1)));
    do_nack();

    // R2: a write after readout is stored and becomes the newest
    do_write(10'h2C7, 1'b1);
    do_start(1'b1);
    for (int k = 0; k < DEPTH - 2; k++) begin do_ack(); do_ack(); end
    chk("R2 newest is last write", int'(rd_data), hi_b(10'h2C7));
    do_ack();
    chk("R7 newest low bits", int'(rd_data), lo_b(10'h2C7));
    do_nack();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule